// File: doc/BRIEF.md
# Double-Sample Stable Word Capture

This block brings a multi-bit word from a source that runs without regard to the local clock into the clocked domain. A typical source is a free-running ripple counter, whose bits settle at different times. On every clock edge the block samples the word. It passes a value on only when two samples taken on back-to-back edges agree in every bit. A word caught while its bits were still moving therefore never reaches the output; the last agreed value is held instead.

The scheme relies on the source staying put for at least two clock edges after each change. A source that changes more often than that is simply not followed until it settles. A one-cycle flag marks each cycle in which the output takes on a new value, so downstream logic can react to changes without comparing words itself. Reset is applied asynchronously and released in step with the clock.

Top module: `stable_word_capture`

## Requirements
- R1: While reset is asserted and after its release, the output word is all zeros and the update flag is low. With a zero input, the flag stays low after release.
- R2: Drive a new value before a rising edge and hold it for at least two edges. The output shows the value, with the flag high, in the cycle after the third rising edge from that drive.
- R3: The update flag is high for exactly one cycle for each change of the output word, and is never high in two consecutive cycles.
- R4: An input that changes at every rising edge is never accepted. The output keeps its previous value and the flag stays low.
- R5: When a stable pair of samples equals the value already held, the output stays the same and the flag stays low. This covers the input returning to the held value after a one-cycle glitch.
- R6: Two samples that differ in a single bit count as unequal. This holds for the least significant bit (bit 0) and for the most significant bit (bit WORD_W-1).
- R7: If the input changes at the same edge on which a matching pair is accepted, the output takes the matched value, not the new input. In the next cycle the output stays on the matched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| arst_n_i | input | 1 | Active-low reset, applied asynchronously, released through a synchronizer |
| async_word_i | input | WORD_W | Word from a source unrelated to clk_i |
| word_o | output | WORD_W | Last value seen on two consecutive edges |
| word_upd_o | output | 1 | One-cycle pulse when word_o changes |

## Verification
Two events can fall on the same edge: the output register loading a matched pair, and the first sample register catching a fresh input that breaks the next comparison. The bench provokes this by holding a word for exactly two edges and changing the input just before the third edge. It judges the result by requiring the matched word on the output with the flag high after that edge. One cycle later it requires the same word with the flag low, even though the new input has reached the sample path by then. One-cycle glitches that return to the held word also test the other half of the flag logic: a match that loads an unchanged value must not pulse.

// File: rtl/swc_pkg.sv
package swc_pkg;
  // default word width of the captured value
  localparam int SWC_WORD_W_DEF = 8;
  // default depth of the reset release synchronizer
  localparam int SWC_RST_STAGES_DEF = 2;
endpackage

// File: rtl/swc_rst_sync.sv
module swc_rst_sync #(
  parameter int STAGES = swc_pkg::SWC_RST_STAGES_DEF
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/swc_sample_pipe.sv
module swc_sample_pipe #(
  parameter int WORD_W = swc_pkg::SWC_WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] newer_o,
  output logic [WORD_W-1:0] older_o
);
  logic [WORD_W-1:0] newer_q, newer_d;
  logic [WORD_W-1:0] older_q, older_d;

  // record, wait, record: the newer sample moves down each edge
  always_comb begin
    newer_d = word_i;
    older_d = newer_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      newer_q <= '0;
      older_q <= '0;
    end else begin
      newer_q <= newer_d;
      older_q <= older_d;
    end
  end

  assign newer_o = newer_q;
  assign older_o = older_q;
endmodule

// File: rtl/swc_word_compare.sv
module swc_word_compare #(
  parameter int WORD_W = swc_pkg::SWC_WORD_W_DEF
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              same_o
);
  logic [WORD_W-1:0] bit_same;

  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    assign bit_same[g] = ~(a_i[g] ^ b_i[g]);
  end

  assign same_o = &bit_same;
endmodule

// File: rtl/swc_hold_reg.sv
module swc_hold_reg #(
  parameter int WORD_W = swc_pkg::SWC_WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              match_i,
  input  logic [WORD_W-1:0] cand_i,
  output logic [WORD_W-1:0] word_o,
  output logic              upd_o
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              upd_q, upd_d;
  logic              load_en;

  assign load_en = match_i;

  always_comb begin
    word_d = word_q;
    upd_d  = 1'b0;
    if (load_en) begin
      word_d = cand_i;
      upd_d  = (cand_i != word_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      word_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      upd_q  <= upd_d;
    end
  end

  assign word_o = word_q;
  assign upd_o  = upd_q;

  AST_LOAD_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    match_i |=> (word_q == $past(cand_i))); // R2
  AST_HOLD_ON_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !match_i |=> ($stable(word_q) && !upd_q)); // R4
  AST_FLAG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    upd_q |=> !upd_q); // R3
  AST_FLAG_ONLY_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $stable(word_q) |-> !upd_q); // R5
endmodule

// File: rtl/stable_word_capture.sv
module stable_word_capture #(
  parameter int WORD_W     = swc_pkg::SWC_WORD_W_DEF,
  parameter int RST_STAGES = swc_pkg::SWC_RST_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              arst_n_i,
  input  logic [WORD_W-1:0] async_word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_upd_o
);
  logic              rst_n;
  logic [WORD_W-1:0] newer, older;
  logic              same;

  swc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .rst_n_o  (rst_n)
  );

  swc_sample_pipe #(.WORD_W(WORD_W)) u_pipe (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .word_i  (async_word_i),
    .newer_o (newer),
    .older_o (older)
  );

  swc_word_compare #(.WORD_W(WORD_W)) u_cmp (
    .a_i    (newer),
    .b_i    (older),
    .same_o (same)
  );

  swc_hold_reg #(.WORD_W(WORD_W)) u_hold (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .match_i (same),
    .cand_i  (newer),
    .word_o  (word_o),
    .upd_o   (word_upd_o)
  );

  // a single differing bit between the stored samples must block the load
  AST_ONE_BIT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($countones(newer ^ older) == 1) |=> $stable(word_o)); // R6
endmodule

// File: tb/stable_word_capture_tb_top.sv
module stable_word_capture_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] din;
  logic [W-1:0] dout;
  logic         upd;
  int           checks = 0;
  int           failures = 0;
  bit           done = 1'b0;
  logic [W-1:0] model = '0;

  always #5 clk = ~clk;

  stable_word_capture #(.WORD_W(W)) dut_i (
    .clk_i        (clk),
    .arst_n_i     (rst_n),
    .async_word_i (din),
    .word_o       (dout),
    .word_upd_o   (upd)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [W-1:0] exp_w, input logic exp_f);
    chk(dout === exp_w, {req, " word"}, dout, exp_w);
    chk(upd === exp_f, {req, " flag"}, {{(W-1){1'b0}}, upd}, {{(W-1){1'b0}}, exp_f});
  endtask

  // R1: reset value and quiet flag after release
  task automatic t_reset();
    rst_n = 1'b0;
    din   = 8'hA5;
    repeat (3) @(negedge clk);
    chk_state("R1 in reset", '0, 1'b0);
    din   = '0;
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk_state("R1 after release", '0, 1'b0);
    end
    model = '0;
  endtask

  // R2 and R3: stable word shows up after the third edge, one flag pulse
  task automatic t_accept(input logic [W-1:0] val);
    din = val;
    @(negedge clk); chk_state("R2 edge1", model, 1'b0);
    @(negedge clk); chk_state("R2 edge2", model, 1'b0);
    @(negedge clk); chk_state("R2 edge3", val, 1'b1);
    model = val;
    @(negedge clk); chk_state("R3 pulse end", val, 1'b0);
    @(negedge clk); chk_state("R3 steady", val, 1'b0);
  endtask

  // R4 / R6: input changing at every edge is never taken
  task automatic t_toggle(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      din = (i % 2 == 1) ? b : a;
      @(negedge clk);
      chk_state(req, model, 1'b0);
    end
  endtask

  // R5: glitch then return to the held word gives no pulse
  task automatic t_same(input logic [W-1:0] glitch);
    din = glitch;
    @(negedge clk); chk_state("R5 glitch", model, 1'b0);
    din = model;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk_state("R5 return", model, 1'b0);
    end
  endtask

  // R7: input changes on the edge that accepts the matched pair
  task automatic t_collide(input logic [W-1:0] d, input logic [W-1:0] x,
                           input logic [W-1:0] y);
    din = d;
    @(negedge clk); chk_state("R7 edge1", model, 1'b0);
    @(negedge clk); chk_state("R7 edge2", model, 1'b0);
    din = x;
    @(negedge clk); chk_state("R7 accept", d, 1'b1);
    model = d;
    din = y;
    @(negedge clk); chk_state("R7 after", d, 1'b0);
  endtask

  initial begin
    din   = '0;
    rst_n = 1'b0;
    t_reset();
    t_accept(8'h3C);
    t_accept(8'hC3);
    t_toggle(8'h55, 8'hAA, 12, "R4 toggle");
    t_accept(8'h81);
    t_toggle(8'h01, 8'h81, 10, "R6 msb only");
    t_accept(8'h10);
    t_toggle(8'h11, 8'h10, 10, "R6 lsb only");
    t_accept(8'hFF);
    t_same(8'hFE);
    t_collide(8'h42, 8'h24, 8'h99);
    t_accept(8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule